// File: doc/BRIEF.md
# Gated Hold PWM Generator

This block drives the hold pin of a solenoid channel with a pulse-width modulated waveform. It stays idle until the sequencer sends a one-cycle start pulse. It then runs until a one-cycle stop pulse arrives for note-off. The waveform comes from an up-counter with a programmable top value and an 8-bit duty compare value. The counter advances on ticks from a prescaler, whose power-of-two ratio is set by a 4-bit divider code.

Duty, top and divider code are plain configuration levels, and duty and top may change at any moment. At start the counter is preset to the top value, so the first tick is a wrap: it latches the duty and top values and begins a full-width pulse at once. The prescaler restarts at every start and every stop. Because of this, the first tick after a start always arrives one full prescaler period later. All pins are plain control or level pins. No data stream crosses the block's boundary, so it has no valid/ready handshake.

Top module: `hold_pwm_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first start pulse, `hold_o` is low.
- R2: In the cycle after a start edge, `hold_o` is low and the counter holds the current `top_i`. With divider ratio D, `hold_o` first rises exactly D clock edges after the start edge, provided the duty is nonzero.
- R3: The divider code is captured at start. A code n from 1 to 15 makes one tick every 2^(n-1) clock cycles, so code 2 divides by 2, code 5 by 16 and code 15 by 16384. Code 0 produces no ticks, and `hold_o` stays low.
- R4: One PWM period lasts top+1 ticks. Each period begins with a wrap tick that raises `hold_o`. When 0 < duty < top, `hold_o` stays high for exactly duty ticks of each period, and the counter never exceeds the latched top.
- R5: A latched duty of 0 keeps `hold_o` low for the whole period.
- R6: A latched duty greater than or equal to the latched top keeps `hold_o` high for the whole period. This includes top = 0.
- R7: Duty and top are sampled only at a wrap tick. A change made in the middle of a period takes effect from the next period on.
- R8: A stop pulse drives `hold_o` low in the next cycle and halts the prescaler. The output then stays low until the next start. When start and stop arrive in the same cycle, stop wins.
- R9: A start that follows a stop restarts the prescaler from zero. The timing of R2 then holds again, whatever phase the prescaler had reached when it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that enables the hold waveform |
| stop_i | input | 1 | One-cycle pulse that ends the hold waveform (note-off) |
| duty_i | input | 8 | Duty compare value, 0 to 255, sampled at each wrap |
| top_i | input | 8 | Counter top value, sampled at start and at each wrap |
| div_code_i | input | 4 | Prescaler code, captured at start; 0 stops the counter |
| hold_o | output | 1 | Hold PWM output |

## Verification
The checker watches several properties on every cycle. It confirms that the output is low after any start or stop edge, and that a rising output always follows a prescaler tick. It confirms that the spacing between ticks equals two to the power of the captured code minus one, and that code 0 gives no ticks. It also confirms that the counter stays within the latched top and that a high output implies a nonzero latched duty. Other behaviours are visible only in the bench scenarios, because they depend on accumulated history. These are the exact rise time after start, the high time per period, the timing of a mid-period duty change, the full-period high level when duty is at or above top, and the restart timing after a stop. The bench compares the output on every cycle against a waveform it computes from the requirements.

// File: rtl/hpwm_pkg.sv
package hpwm_pkg;

  // Action the period counter hands to the output stage for one cycle.
  typedef enum logic [1:0] {
    ACT_KEEP  = 2'd0,
    ACT_CLEAR = 2'd1,
    ACT_LOAD  = 2'd2
  } hold_act_e;

  // Prescaler counter width needed for the largest code of a CODE_W-bit field.
  function automatic int unsigned pre_width(int unsigned code_w);
    return (1 << code_w) - 2;
  endfunction

endpackage

// File: rtl/hpwm_prescaler.sv
module hpwm_prescaler #(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned PRE_W  = hpwm_pkg::pre_width(CODE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);

  logic              run_q;
  logic [CODE_W-1:0] code_q;
  logic [PRE_W-1:0]  pre_q;
  logic [PRE_W-1:0]  limit;
  logic [CODE_W-1:0] shamt;

  // Terminal count is 2^(code-1)-1: a mask of (code-1) low ones.
  always_comb begin
    shamt = code_q - CODE_W'(1);
    limit = ~({PRE_W{1'b1}} << shamt);
  end

  assign tick_o = run_q && (code_q != '0) && (pre_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      code_q <= '0;
      pre_q  <= '0;
    end else if (stop_i) begin
      run_q  <= 1'b0;
      code_q <= '0;
      pre_q  <= '0;
    end else if (start_i) begin
      run_q  <= 1'b1;
      code_q <= code_i;
      pre_q  <= '0;
    end else if (tick_o) begin
      pre_q  <= '0;
    end else if (run_q && (code_q != '0)) begin
      pre_q  <= pre_q + PRE_W'(1);
    end
  end

endmodule

// File: rtl/hpwm_counter.sv
module hpwm_counter
  import hpwm_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic [CNT_W-1:0] duty_i,
  output hold_act_e        act_o,
  output logic             level_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] top_q_o,
  output logic [CNT_W-1:0] duty_q_o
);

  logic [CNT_W-1:0] cnt_q, top_q, duty_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             wrap;
  logic             match;

  assign cnt_inc = cnt_q + CNT_W'(1);
  assign wrap    = (cnt_q >= top_q);
  // A compare value at or above top never ends the pulse (full-period high).
  assign match   = (cnt_inc == duty_q) && (duty_q < top_q);

  always_comb begin
    act_o   = ACT_KEEP;
    level_o = (duty_i != '0);
    if (tick_i) begin
      if (wrap)       act_o = ACT_LOAD;
      else if (match) act_o = ACT_CLEAR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      top_q  <= '0;
      duty_q <= '0;
    end else if (start_i) begin
      // Preset to top: the first tick is a wrap that latches fresh values.
      cnt_q  <= top_i;
      top_q  <= top_i;
    end else if (tick_i) begin
      if (wrap) begin
        cnt_q  <= '0;
        top_q  <= top_i;
        duty_q <= duty_i;
      end else begin
        cnt_q  <= cnt_inc;
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign top_q_o  = top_q;
  assign duty_q_o = duty_q;

endmodule

// File: rtl/hpwm_out_stage.sv
module hpwm_out_stage
  import hpwm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  logic      stop_i,
  input  hold_act_e act_i,
  input  logic      level_i,
  output logic      hold_o
);

  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
    end else if (stop_i || start_i) begin
      hold_q <= 1'b0;
    end else begin
      unique case (act_i)
        ACT_LOAD:  hold_q <= level_i;
        ACT_CLEAR: hold_q <= 1'b0;
        default:   hold_q <= hold_q;
      endcase
    end
  end

  assign hold_o = hold_q;

endmodule

// File: rtl/hold_pwm_gen.sv
module hold_pwm_gen
  import hpwm_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [CNT_W-1:0]  duty_i,
  input  logic [CNT_W-1:0]  top_i,
  input  logic [CODE_W-1:0] div_code_i,
  output logic              hold_o
);

  logic             tick_w;
  hold_act_e        act_w;
  logic             level_w;
  logic [CNT_W-1:0] cnt_w, top_q_w, duty_q_w;

  hpwm_prescaler #(.CODE_W(CODE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .stop_i  (stop_i),
    .code_i  (div_code_i),
    .tick_o  (tick_w)
  );

  hpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .tick_i   (tick_w),
    .top_i    (top_i),
    .duty_i   (duty_i),
    .act_o    (act_w),
    .level_o  (level_w),
    .cnt_o    (cnt_w),
    .top_q_o  (top_q_w),
    .duty_q_o (duty_q_w)
  );

  hpwm_out_stage u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .stop_i  (stop_i),
    .act_i   (act_w),
    .level_i (level_w),
    .hold_o  (hold_o)
  );

endmodule

// File: rtl/hold_pwm_chk.sv
module hold_pwm_chk #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned CODE_W = 4,
  parameter int unsigned GAP_W  = 1 << CODE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              stop_i,
  input logic [CODE_W-1:0] div_code_i,
  input logic              hold_o,
  input logic              tick,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  top_q,
  input logic [CNT_W-1:0]  duty_q
);

  logic [CODE_W-1:0] chk_code;
  logic [GAP_W-1:0]  gap;
  logic [GAP_W-1:0]  gap_exp;

  assign gap_exp = {{(GAP_W-1){1'b0}}, 1'b1} << (chk_code - CODE_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_code <= '0;
      gap      <= '0;
    end else if (stop_i) begin
      chk_code <= '0;
      gap      <= '0;
    end else if (start_i) begin
      chk_code <= div_code_i;
      gap      <= GAP_W'(1);
    end else if (tick) begin
      gap      <= GAP_W'(1);
    end else if (gap != '1) begin
      gap      <= gap + GAP_W'(1);
    end
  end

  assert_stop_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !hold_o);

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !hold_o);

  assert_rise_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_o) |-> $past(tick));

  assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (chk_code != '0) && (gap == gap_exp));

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= top_q);

  assert_zero_duty_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |-> (duty_q != '0));

endmodule

bind hold_pwm_gen hold_pwm_chk #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .stop_i     (stop_i),
  .div_code_i (div_code_i),
  .hold_o     (hold_o),
  .tick       (tick_w),
  .cnt        (cnt_w),
  .top_q      (top_q_w),
  .duty_q     (duty_q_w)
);

// File: tb/tb_hold_pwm_gen.sv
module tb_hold_pwm_gen;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic       stop_i;
  logic [7:0] duty_i;
  logic [7:0] top_i;
  logic [3:0] div_code_i;
  logic       hold_o;

  int n_checks;
  int n_fail;
  bit done;

  hold_pwm_gen dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .duty_i     (duty_i),
    .top_i      (top_i),
    .div_code_i (div_code_i),
    .hold_o     (hold_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int div_of(int code);
    if (code == 0) return 0;
    return 1 << (code - 1);
  endfunction

  // Expected output t edges after the start edge (R2, R4-R7).
  function automatic bit exp_out(int t, int d, int tp, int dold, int dnew, int tchg);
    int k, m, p, we, du;
    if (d == 0) return 1'b0;
    k = t / d;
    if (k == 0) return 1'b0;
    m  = (k - 1) / (tp + 1);
    p  = (k - 1) % (tp + 1);
    we = d * (1 + m * (tp + 1));
    du = (we > tchg) ? dnew : dold;
    if (du == 0) return 1'b0;
    if (du >= tp) return 1'b1;
    return (p < du);
  endfunction

  task automatic check(bit got, bit exp, string req, int t);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0d actual=%0b expected=%0b", req, t, got, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop_i = 1'b1;
    @(negedge clk) stop_i = 1'b0;
  endtask

  // Starts with the given config and compares every cycle for ncyc cycles.
  task automatic run_cfg(int code, int tp, int dold, int dnew, int tchg,
                         int ncyc, string req);
    div_code_i = 4'(code);
    top_i      = 8'(tp);
    duty_i     = 8'(dold);
    pulse_start();
    for (int t = 0; t <= ncyc; t++) begin
      if (t > 0) @(negedge clk);
      check(hold_o, exp_out(t, div_of(code), tp, dold, dnew, tchg), req, t);
      if (t == tchg) duty_i = 8'(dnew);
    end
  endtask

  task automatic hold_low(int ncyc, string req);
    for (int t = 0; t < ncyc; t++) begin
      check(hold_o, 1'b0, req, t);
      @(negedge clk);
    end
  endtask

  initial begin
    int code, tp, du, len;
    void'($urandom(32'd1234));
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; start_i = 1'b0; stop_i = 1'b0;
    duty_i = 8'd5; top_i = 8'd10; div_code_i = 4'd2;
    repeat (3) @(negedge clk);
    check(hold_o, 1'b0, "R1", 0);
    rst_n = 1'b1;
    hold_low(20, "R1");

    // Random configs: R2 first rise, R4 period and high time
    for (int i = 0; i < 10; i++) begin
      code = 1 + int'($urandom % 5);
      tp   = int'($urandom % 21);
      du   = int'($urandom % 25);
      len  = div_of(code) * (tp + 1) * 3 + 5;
      run_cfg(code, tp, du, du, 1 << 30, len, "R4");
      pulse_stop();
    end

    // Directed corners
    run_cfg(1, 7, 3, 3, 1 << 30, 40, "R2");
    pulse_stop();
    run_cfg(2, 10, 0, 0, 1 << 30, 80, "R5");
    pulse_stop();
    run_cfg(2, 9, 9, 9, 1 << 30, 70, "R6");
    pulse_stop();
    run_cfg(1, 6, 200, 200, 1 << 30, 40, "R6");
    pulse_stop();
    run_cfg(3, 0, 3, 3, 1 << 30, 40, "R6");
    pulse_stop();
    run_cfg(0, 4, 2, 2, 1 << 30, 300, "R3");
    pulse_stop();
    run_cfg(5, 3, 1, 1, 1 << 30, 16 * 4 * 2 + 3, "R3");
    pulse_stop();
    run_cfg(15, 1, 1, 1, 1 << 30, 16384 * 2 + 5, "R3");
    pulse_stop();
    // Mid-period duty change: new value applies from the next wrap (R7)
    run_cfg(2, 10, 3, 7, 15, 90, "R7");
    pulse_stop();

    // Stop in mid-pulse, then stays low (R8)
    run_cfg(1, 20, 15, 15, 1 << 30, 6, "R8");
    @(negedge clk) stop_i = 1'b1;
    @(negedge clk) stop_i = 1'b0;
    hold_low(100, "R8");

    // Simultaneous start and stop: stop wins (R8)
    div_code_i = 4'd1; top_i = 8'd4; duty_i = 8'd2;
    @(negedge clk) begin start_i = 1'b1; stop_i = 1'b1; end
    @(negedge clk) begin start_i = 1'b0; stop_i = 1'b0; end
    hold_low(60, "R8");

    // Stop at an odd prescaler phase, restart with fresh timing (R9)
    run_cfg(3, 5, 2, 2, 1 << 30, 7, "R9");
    pulse_stop();
    run_cfg(3, 5, 2, 2, 1 << 30, 60, "R9");
    pulse_stop();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(150000 * 4);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule